// File: doc/BRIEF.md
# System-Management Active Indicator

This block produces the active-low indicator that tells external hardware, for example a secondary cache controller or a memory decoder, that system-management memory is in use. The indicator works in one of two ways. In compatibility mode it is a sticky level. It goes low when the processor enters system-management state, through a request pin or an entry instruction, and stays low until a resume instruction. It is also low during enabled accesses to the protected region and during snoop write-backs that start while it is low. In enhanced mode it is a per-bus-cycle qualifier. It is launched together with the registered memory/IO and write/read cycle-definition outputs, and marks only cycles that target system-management memory.

A small configuration register holds three bits: enable, region-access enable and mode select. Reset clears all three, and the output stays high while enable is clear. A new mode takes effect only when the next bus cycle starts. During bus hold the output driver stays on, except while an enhanced-mode system-management cycle is current, when the driver is released.

Top module: `smm_ind_ctrl`

## Requirements
- R1: After synchronous reset, `smi_act_n` is 1, `smi_act_oe` is 1, `mio_o` and `wr_o` are 0, and the whole configuration register is 0.
- R2: Configuration bit 0 is the enable. While it is 0, `smi_act_n` is 1 whatever the other inputs do. A request seen while it is 0 leaves no pending entry behind once enable is set again.
- R3: In compatibility mode (configuration bit 2 = 0) with enable set, `smint_stb` drives `smi_act_n` low one clock later. `smi_req` passes through SYNC_STAGES flops first and drives it low SYNC_STAGES+1 clocks after it is sampled.
- R4: Once entered, the system-management state and the low output hold until `rsm_stb`, which drives `smi_act_n` high one clock later.
- R5: An entry request while already in the state changes nothing. `rsm_stb` outside the state changes nothing.
- R6: In compatibility mode with configuration bit 1 (region access) set, a bus cycle flagged `cyc_smm_mem` holds `smi_act_n` low from the clock after its `cyc_start` until the next `cyc_start`. With bit 1 clear it has no effect.
- R7: In compatibility mode, a cycle that starts with `cyc_wb` and `cyc_inq` both set while the output is low keeps the output low until the next `cyc_start`, even if resume occurs in between.
- R8: In enhanced mode (configuration bit 2 = 1), `smi_act_n` is low exactly while the current bus cycle is flagged `cyc_smm_mem`, and is high for other cycles even while in the system-management state.
- R9: In enhanced mode, `smi_act_n`, `mio_o` and `wr_o` change on the same clock, the one after `cyc_start`.
- R10: `smi_act_oe` is 1 whenever `hold_ack` is 0, and also during hold, except when enhanced mode, enable and a current system-management cycle coincide, which makes it 0.
- R11: A write to the mode bit takes effect only at the next `cyc_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 3 | Configuration data: bit 0 enable, bit 1 region access, bit 2 mode (1 = enhanced) |
| smi_req | input | 1 | Asynchronous system-management request |
| smint_stb | input | 1 | Entry instruction strobe |
| rsm_stb | input | 1 | Resume instruction strobe |
| cyc_start | input | 1 | Bus cycle start strobe |
| cyc_smm_mem | input | 1 | Cycle targets system-management memory |
| cyc_wb | input | 1 | Cycle is a write-back |
| cyc_inq | input | 1 | Write-back caused by an inquiry cycle |
| cyc_mio | input | 1 | Cycle memory/IO definition |
| cyc_wr | input | 1 | Cycle write/read definition |
| hold_ack | input | 1 | Bus is in hold |
| smi_act_n | output | 1 | Active-low indicator |
| smi_act_oe | output | 1 | Indicator driver enable |
| mio_o | output | 1 | Registered memory/IO definition |
| wr_o | output | 1 | Registered write/read definition |

## Verification
The bench uses the default SYNC_STAGES of 2, so the request pin enters the state three clocks after it is sampled. The entry instruction takes one clock. Seeing both latencies in one run shows that the two entry paths are counted separately. With the configuration at three bits, every combination of mode, region access and enable used in the table can be written in one cycle. That lets the pending-mode window and the snoop write-back that outlives a resume be checked edge by edge.

// File: rtl/smm_ind_pkg.sv
package smm_ind_pkg;

    localparam int CFG_W = 3;

    typedef enum logic {
        MODE_COMPAT = 1'b0,
        MODE_ENH    = 1'b1
    } smm_mode_e;

    // bit 2 mode, bit 1 region access, bit 0 enable
    typedef struct packed {
        smm_mode_e mode;
        logic      acc_en;
        logic      en;
    } smm_cfg_t;

    typedef struct packed {
        logic smm_mem;
        logic wb;
        logic inq;
        logic mio;
        logic wr;
    } bus_cyc_t;

    localparam bus_cyc_t CYC_IDLE = '{smm_mem: 1'b0, wb: 1'b0, inq: 1'b0,
                                      mio: 1'b0, wr: 1'b0};

    function automatic logic is_snoop_wb(input bus_cyc_t c);
        return c.wb & c.inq;
    endfunction

    function automatic logic smm_target(input bus_cyc_t c, input logic valid);
        return valid & c.smm_mem;
    endfunction

endpackage

// File: rtl/smm_cfg_reg.sv
module smm_cfg_reg
    import smm_ind_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [CFG_W-1:0]    cfg_wdata,
    input  logic                cyc_start,
    output smm_cfg_t            cfg_q,
    output smm_mode_e           mode_act
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{mode: MODE_COMPAT, acc_en: 1'b0, en: 1'b0};
        end else if (cfg_we) begin
            cfg_q <= smm_cfg_t'(cfg_wdata);
        end
    end

    // the mode in force only moves on a bus-cycle boundary
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_act <= MODE_COMPAT;
        end else if (cyc_start) begin
            mode_act <= cfg_q.mode;
        end
    end
endmodule

// File: rtl/smm_state_trk.sv
module smm_state_trk #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic smi_req,
    input  logic smint_stb,
    input  logic rsm_stb,
    output logic smi_seen,
    output logic in_smm
);
    generate
        if (SYNC_STAGES == 0) begin : g_nosync
            assign smi_seen = smi_req;
        end else begin : g_sync
            logic [SYNC_STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain <= '0;
                end else begin
                    chain <= {chain[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], smi_req};
                end
            end
            assign smi_seen = chain[SYNC_STAGES-1];
        end
    endgenerate

    logic enter;
    assign enter = en & ~in_smm & (smi_seen | smint_stb);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            in_smm <= 1'b0;
        end else if (enter) begin
            in_smm <= 1'b1;
        end else if (in_smm && rsm_stb) begin
            in_smm <= 1'b0;
        end
    end
endmodule

// File: rtl/smm_cyc_qual.sv
module smm_cyc_qual
    import smm_ind_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cyc_start,
    input  bus_cyc_t cyc_in,
    input  logic     act_now,
    output bus_cyc_t cur,
    output logic     cur_valid,
    output logic     wb_hold
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur       <= CYC_IDLE;
            cur_valid <= 1'b0;
            wb_hold   <= 1'b0;
        end else if (cyc_start) begin
            cur       <= cyc_in;
            cur_valid <= 1'b1;
            wb_hold   <= is_snoop_wb(cyc_in) & act_now;
        end
    end
endmodule

// File: rtl/smm_pin_drv.sv
module smm_pin_drv
    import smm_ind_pkg::*;
(
    input  smm_cfg_t  cfg_q,
    input  smm_mode_e mode_act,
    input  logic      in_smm,
    input  bus_cyc_t  cur,
    input  logic      cur_valid,
    input  logic      wb_hold,
    input  logic      hold_ack,
    output logic      act,
    output logic      smi_act_n,
    output logic      smi_act_oe
);
    logic act_compat;
    logic act_enh;

    always_comb begin
        act_enh    = smm_target(cur, cur_valid);
        act_compat = in_smm
                   | (cfg_q.acc_en & smm_target(cur, cur_valid))
                   | (cur_valid & wb_hold);
        act        = cfg_q.en & ((mode_act == MODE_ENH) ? act_enh : act_compat);
        smi_act_n  = ~act;
        smi_act_oe = ~(hold_ack & cfg_q.en & (mode_act == MODE_ENH) & act_enh);
    end
endmodule

// File: rtl/smm_ind_ctrl.sv
module smm_ind_ctrl
    import smm_ind_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             smi_req,
    input  logic             smint_stb,
    input  logic             rsm_stb,
    input  logic             cyc_start,
    input  logic             cyc_smm_mem,
    input  logic             cyc_wb,
    input  logic             cyc_inq,
    input  logic             cyc_mio,
    input  logic             cyc_wr,
    input  logic             hold_ack,
    output logic             smi_act_n,
    output logic             smi_act_oe,
    output logic             mio_o,
    output logic             wr_o
);
    smm_cfg_t  cfg_q;
    smm_mode_e mode_act;
    bus_cyc_t  cyc_in;
    bus_cyc_t  cur;
    logic      cur_valid;
    logic      wb_hold;
    logic      in_smm;
    logic      smi_seen;
    logic      act;
    logic      cfg_en;
    logic      mode_enh;

    assign cyc_in   = '{smm_mem: cyc_smm_mem, wb: cyc_wb, inq: cyc_inq,
                        mio: cyc_mio, wr: cyc_wr};
    assign cfg_en   = cfg_q.en;
    assign mode_enh = (mode_act == MODE_ENH);

    smm_cfg_reg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cyc_start (cyc_start),
        .cfg_q     (cfg_q),
        .mode_act  (mode_act)
    );

    smm_state_trk #(.SYNC_STAGES(SYNC_STAGES)) u_trk (
        .clk       (clk),
        .rst       (rst),
        .en        (cfg_q.en),
        .smi_req   (smi_req),
        .smint_stb (smint_stb),
        .rsm_stb   (rsm_stb),
        .smi_seen  (smi_seen),
        .in_smm    (in_smm)
    );

    smm_cyc_qual u_qual (
        .clk       (clk),
        .rst       (rst),
        .cyc_start (cyc_start),
        .cyc_in    (cyc_in),
        .act_now   (act),
        .cur       (cur),
        .cur_valid (cur_valid),
        .wb_hold   (wb_hold)
    );

    smm_pin_drv u_drv (
        .cfg_q      (cfg_q),
        .mode_act   (mode_act),
        .in_smm     (in_smm),
        .cur        (cur),
        .cur_valid  (cur_valid),
        .wb_hold    (wb_hold),
        .hold_ack   (hold_ack),
        .act        (act),
        .smi_act_n  (smi_act_n),
        .smi_act_oe (smi_act_oe)
    );

    assign mio_o = cur.mio;
    assign wr_o  = cur.wr;
endmodule

// File: rtl/smm_ind_chk.sv
module smm_ind_chk (
    input logic clk,
    input logic rst,
    input logic cfg_we,
    input logic smint_stb,
    input logic rsm_stb,
    input logic cyc_start,
    input logic hold_ack,
    input logic smi_act_n,
    input logic smi_act_oe,
    input logic cfg_en,
    input logic mode_enh,
    input logic in_smm,
    input logic smi_seen
);
    AST_DISABLED_HIGH: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |-> smi_act_n);  // R2

    AST_ENTRY_INSTR: assert property (@(posedge clk) disable iff (rst)
        cfg_en && !cfg_we && smint_stb && !in_smm |=> in_smm);  // R3

    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        cfg_en && !cfg_we && in_smm && !rsm_stb |=> in_smm);  // R4

    AST_STRAY_RESUME: assert property (@(posedge clk) disable iff (rst)
        !in_smm && rsm_stb && !smint_stb && !smi_seen |=> !in_smm);  // R5

    AST_ENH_TIMING: assert property (@(posedge clk) disable iff (rst)
        mode_enh && cfg_en && !cyc_start && !cfg_we |=> $stable(smi_act_n));  // R9

    AST_DRIVEN_NO_HOLD: assert property (@(posedge clk) disable iff (rst)
        !hold_ack |-> smi_act_oe);  // R10

    AST_MODE_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        !cyc_start |=> $stable(mode_enh));  // R11
endmodule

bind smm_ind_ctrl smm_ind_chk u_chk (.*);

// File: tb/smm_ind_ctrl_bench.sv
module smm_ind_ctrl_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_wdata = 3'd0;
    logic smi_req = 1'b0, smint_stb = 1'b0, rsm_stb = 1'b0;
    logic cyc_start = 1'b0, cyc_smm_mem = 1'b0, cyc_wb = 1'b0, cyc_inq = 1'b0;
    logic cyc_mio = 1'b0, cyc_wr = 1'b0, hold_ack = 1'b0;
    logic smi_act_n, smi_act_oe, mio_o, wr_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    smm_ind_ctrl u_smm_ind_ctrl (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .smi_req(smi_req), .smint_stb(smint_stb), .rsm_stb(rsm_stb),
        .cyc_start(cyc_start), .cyc_smm_mem(cyc_smm_mem), .cyc_wb(cyc_wb),
        .cyc_inq(cyc_inq), .cyc_mio(cyc_mio), .cyc_wr(cyc_wr),
        .hold_ack(hold_ack), .smi_act_n(smi_act_n), .smi_act_oe(smi_act_oe),
        .mio_o(mio_o), .wr_o(wr_o)
    );

    typedef struct packed {
        logic       we;
        logic [2:0] wd;
        logic       smi, smint, rsm, st, sm, wb, inq, mio, wr, hold;
        logic       exp_n, exp_oe;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 24;
    // cfg bits: [0] enable, [1] region access, [2] mode (1 = enhanced)
    localparam vec_t TBL [NV] = '{
        //  we  wd    smi  smnt rsm  st   sm   wb   inq  mio  wr   hold  n    oe   req
        '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,4'd1},  // R1 idle
        '{1'b1,3'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,4'd2},  // R2 enable only
        '{1'b0,3'd0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,4'd3},  // R3 entry instr
        '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,4'd4},  // R4 sticky
        '{1'b0,3'd0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,4'd5},  // R5 re-entry ignored
        '{1'b0,3'd0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,4'd4},  // R4 resume
        '{1'b0,3'd0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,4'd5},  // R5 stray resume
        '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,4'd6},  // R6 no access enable
        '{1'b1,3'd3,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,4'd6},  // R6 access enabled
        '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,4'd6},  // R6 normal cycle
        '{1'b0,3'd0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,4'd3},  // R3 enter again
        '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,4'd7},  // R7 snoop wb
        '{1'b0,3'd0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,4'd7},  // R7 outlives resume
        '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,4'd7},  // R7 ends at next cycle
        '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,4'd10}, // R10 compat hold
        '{1'b1,3'd7,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,4'd11}, // R11 mode pending
        '{1'b0,3'd0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,4'd11}, // R11 still compat
        '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,4'd8},  // R8 in state, plain cycle
        '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,4'd8},  // R8 smm cycle
        '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,4'd10}, // R10 float
        '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,4'd8},  // R8 plain cycle
        '{1'b1,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,4'd2},  // R2 disabled
        '{1'b0,3'd0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,4'd2},  // R2 entry ignored
        '{1'b1,3'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,4'd2}   // R2 nothing latent
    };

    task automatic chk(input string rq, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", rq, what, act, exp);
        end
    endtask

    task automatic idle();
        cfg_we = 1'b0; cfg_wdata = 3'd0; smi_req = 1'b0; smint_stb = 1'b0;
        rsm_stb = 1'b0; cyc_start = 1'b0; cyc_smm_mem = 1'b0; cyc_wb = 1'b0;
        cyc_inq = 1'b0; cyc_mio = 1'b0; cyc_wr = 1'b0; hold_ack = 1'b0;
    endtask

    task automatic do_reset();
        idle();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        do_reset();
        chk("R1", "smi_act_n", smi_act_n, 1'b1);
        chk("R1", "smi_act_oe", smi_act_oe, 1'b1);
        chk("R1", "mio_o", mio_o, 1'b0);
        chk("R1", "wr_o", wr_o, 1'b0);

        for (int i = 0; i < NV; i++) begin
            cfg_we = TBL[i].we; cfg_wdata = TBL[i].wd; smi_req = TBL[i].smi;
            smint_stb = TBL[i].smint; rsm_stb = TBL[i].rsm; cyc_start = TBL[i].st;
            cyc_smm_mem = TBL[i].sm; cyc_wb = TBL[i].wb; cyc_inq = TBL[i].inq;
            cyc_mio = TBL[i].mio; cyc_wr = TBL[i].wr; hold_ack = TBL[i].hold;
            @(negedge clk);
            chk($sformatf("R%0d row %0d", TBL[i].rq, i), "smi_act_n", smi_act_n, TBL[i].exp_n);
            chk($sformatf("R%0d row %0d", TBL[i].rq, i), "smi_act_oe", smi_act_oe, TBL[i].exp_oe);
        end
        idle();

        // R3: request pin goes through two synchronizer flops, low after third edge
        do_reset();
        cfg_we = 1'b1; cfg_wdata = 3'd1;
        @(negedge clk);
        idle();
        smi_req = 1'b1;
        @(negedge clk);
        smi_req = 1'b0;
        chk("R3", "smi_act_n after edge 1", smi_act_n, 1'b1);
        @(negedge clk);
        chk("R3", "smi_act_n after edge 2", smi_act_n, 1'b1);
        @(negedge clk);
        chk("R3", "smi_act_n after edge 3", smi_act_n, 1'b0);
        // R5: a second request while inside changes nothing, resume still exits
        smi_req = 1'b1;
        @(negedge clk);
        smi_req = 1'b0;
        repeat (3) @(negedge clk);
        chk("R5", "smi_act_n in state", smi_act_n, 1'b0);
        rsm_stb = 1'b1;
        @(negedge clk);
        rsm_stb = 1'b0;
        chk("R4", "smi_act_n after resume", smi_act_n, 1'b1);

        // R9: enhanced output launched with the cycle definition outputs
        cfg_we = 1'b1; cfg_wdata = 3'd5;
        @(negedge clk);
        cfg_we = 1'b0;
        cyc_start = 1'b1; cyc_smm_mem = 1'b1; cyc_mio = 1'b1; cyc_wr = 1'b0;
        chk("R9", "smi_act_n before start", smi_act_n, 1'b1);
        chk("R9", "mio_o before start", mio_o, 1'b0);
        @(negedge clk);
        chk("R9", "smi_act_n with cycle", smi_act_n, 1'b0);
        chk("R9", "mio_o with cycle", mio_o, 1'b1);
        chk("R9", "wr_o with cycle", wr_o, 1'b0);
        cyc_smm_mem = 1'b0; cyc_mio = 1'b0; cyc_wr = 1'b1;
        @(negedge clk);
        idle();
        chk("R9", "smi_act_n next cycle", smi_act_n, 1'b1);
        chk("R9", "mio_o next cycle", mio_o, 1'b0);
        chk("R9", "wr_o next cycle", wr_o, 1'b1);

        done = 1'b1;
        finish_run();
    end
endmodule